// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block models a serial EEPROM that answers on an open-drain two-wire bus and holds 2048 bytes. It oversamples the bus clock and data lines with the system clock. It finds start and stop conditions and accepts a select byte that carries three strap bits, so up to eight such targets can share one bus. A write names an 11-bit word address in two bytes, then sends data. A read either names an address first (random read) or continues from the current address.

Written bytes gather in a 16-byte page buffer. A stop condition commits the bytes that arrived, even if the page is only partly filled. A busy period follows, set by a cycle-count parameter. During that period the target ignores its select byte, so the master can poll until it answers again. A write-protect input blocks the commit while the bus exchange carries on as normal.

Top module: `eep_two_wire_target`

## Requirements
- R1: After reset the target releases SDA (sda_oe_o low), and every array byte reads back as 8'hFF.
- R2: The select byte is, from MSB to LSB, the code 4'b1010, then strap_i[2], strap_i[1], strap_i[0], then a direction bit (1 = read). The target acknowledges only when the code and all three strap bits match. On a mismatch it keeps SDA released until the next start.
- R3: Each accepted select byte, address byte and write-data byte is acknowledged by pulling SDA low for the whole ninth clock pulse.
- R4: The first address byte after a write select carries address bits 10..8 in its bits 2..0. The second carries bits 7..0. A repeated start followed by a read select then returns the byte at that address.
- R5: Write data goes to a 16-byte page. Consecutive bytes advance only the low 4 address bits, wrapping within the page. More than 16 bytes overwrite earlier ones in page order. A stop commits exactly the page positions that were received.
- R6: A read returns successive bytes while the master acknowledges. The full 11-bit address advances after each byte and wraps from 2047 to 0. A later read with no address phase continues from the byte after the last one sent.
- R7: A stop that ends a write with at least one data byte starts a busy period of WR_CYCLES clocks. During that period a select byte is not acknowledged. Afterwards the target answers, and the new data can be read back.
- R8: With wp_i high at the stop, every byte is still acknowledged. The array stays unchanged and no busy period starts.
- R9: A start condition that arrives during a write, before any stop, drops the buffered data. Nothing is committed, and no busy period starts.
- R10: When the master does not acknowledge a read byte, the target releases SDA and stays idle until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired line) |
| strap_i | input | 3 | Cascade select straps compared against the select byte |
| wp_i | input | 1 | Write protect; high blocks array updates |
| sda_oe_o | output | 1 | Pull data line low when high |

## Verification
Two events can fall in the same clock: the internal write timer expiring, and the acknowledge decision for a select byte. The bench provokes this by polling with select bytes back to back straight after a write's stop. The first poll must be refused. Polling then continues until one is accepted. The result is judged by the clocks that passed between the stop and the first accepted poll, which must be at least the busy length and not far beyond it, and by reading back the committed page.

// File: rtl/eep_pkg.sv
package eep_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SEL,
      ST_SEL_ACK,
      ST_AHI,
      ST_AHI_ACK,
      ST_ALO,
      ST_ALO_ACK,
      ST_WDAT,
      ST_WDAT_ACK,
      ST_RDAT,
      ST_RDAT_ACK
   } eep_state_t;

   localparam logic [3:0] SEL_CODE = 4'b1010;
endpackage

// File: rtl/eep_bus_sense.sv
module eep_bus_sense #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic rise_o,
   output logic fall_o,
   output logic start_o,
   output logic stop_o
);
   localparam int SH_W = 2 * SYNC_STAGES;

   logic [SH_W-1:0] sh;
   logic [1:0]      prev;
   logic [1:0]      cur;

   initial begin
      assert (SYNC_STAGES >= 1 && SYNC_STAGES <= 4)
         else $error("eep_bus_sense: SYNC_STAGES out of range");
   end

   generate
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '1;
            else        sh <= {scl_i, sda_i};
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '1;
            else        sh <= {sh[SH_W-3:0], scl_i, sda_i};
         end
      end
   endgenerate

   assign cur = sh[SH_W-1 -: 2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 2'b11;
      else        prev <= cur;
   end

   assign scl_o   = cur[1];
   assign sda_o   = cur[0];
   assign rise_o  = cur[1] & ~prev[1];
   assign fall_o  = ~cur[1] & prev[1];
   assign start_o = cur[1] & prev[1] & prev[0] & ~cur[0];
   assign stop_o  = cur[1] & prev[1] & ~prev[0] & cur[0];
endmodule

// File: rtl/eep_store.sv
module eep_store #(
   parameter int ADDR_W = 11,
   parameter int PAGE_W = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          commit_i,
   input  logic [ADDR_W-PAGE_W-1:0]      page_i,
   input  logic [(1<<PAGE_W)-1:0][7:0]   data_i,
   input  logic [(1<<PAGE_W)-1:0]        mask_i,
   input  logic [ADDR_W-1:0]             raddr_i,
   output logic [7:0]                    rdata_o
);
   localparam int MEM_BYTES  = 1 << ADDR_W;
   localparam int PAGE_BYTES = 1 << PAGE_W;

   logic [MEM_BYTES-1:0][7:0] mem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem <= {MEM_BYTES{8'hFF}};
      end else if (commit_i) begin
         for (int l = 0; l < PAGE_BYTES; l++) begin
            if (mask_i[l]) mem[{page_i, PAGE_W'(l)}] <= data_i[l];
         end
      end
   end

   assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/eep_write_timer.sv
module eep_write_timer #(
   parameter int WR_CYCLES = 300
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   localparam int CNT_W = $clog2(WR_CYCLES + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (start_i)      cnt <= CNT_W'(WR_CYCLES);
      else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
   end

   assign busy_o = (cnt != '0);

   // R7: a new write cycle is only launched from the idle state
   a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);

   // R7: busy only begins because a write was launched
   a_r7_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/eep_two_wire_target.sv
module eep_two_wire_target
   import eep_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int PAGE_W      = 4,
   parameter int WR_CYCLES   = 300,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] strap_i,
   input  logic       wp_i,
   output logic       sda_oe_o
);
   localparam int PAGE_BYTES = 1 << PAGE_W;
   localparam int HI_W       = ADDR_W - 8;
   localparam int PG_W       = ADDR_W - PAGE_W;

   initial begin
      assert (ADDR_W >= 9 && ADDR_W <= 16)
         else $error("eep_two_wire_target: ADDR_W must be 9..16");
      assert (PAGE_W >= 1 && PAGE_W <= 8)
         else $error("eep_two_wire_target: PAGE_W must be 1..8");
      assert (WR_CYCLES >= 1)
         else $error("eep_two_wire_target: WR_CYCLES must be positive");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

   eep_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (scl_i),
      .sda_i   (sda_i),
      .scl_o   (scl_s),
      .sda_o   (sda_s),
      .rise_o  (scl_rise),
      .fall_o  (scl_fall),
      .start_o (start_ev),
      .stop_o  (stop_ev)
   );

   eep_state_t                    state;
   logic [3:0]                    bitcnt;
   logic [7:0]                    shreg;
   logic [ADDR_W-1:0]             addr;
   logic                          rw_q;
   logic                          oe_q;
   logic                          mack_q;
   logic [PG_W-1:0]               page_q;
   logic [PAGE_BYTES-1:0][7:0]    pbuf;
   logic [PAGE_BYTES-1:0]         pmask;

   logic                          busy;
   logic                          wr_go;
   logic [7:0]                    rd_byte;
   logic                          sel_hit;
   logic [PAGE_W-1:0]             woff;
   logic [ADDR_W-1:0]             lo_addr;

   assign wr_go   = stop_ev && (pmask != '0) && !wp_i && !busy;
   assign sel_hit = (shreg[7:4] == SEL_CODE) && (shreg[3:1] == strap_i) && !busy;
   assign woff    = addr[PAGE_W-1:0];
   assign lo_addr = {addr[ADDR_W-1:8], shreg};

   eep_write_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (wr_go),
      .busy_o  (busy)
   );

   eep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit_i (wr_go),
      .page_i   (page_q),
      .data_i   (pbuf),
      .mask_i   (pmask),
      .raddr_i  (addr),
      .rdata_o  (rd_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         bitcnt <= '0;
         shreg  <= '0;
         addr   <= '0;
         rw_q   <= 1'b0;
         oe_q   <= 1'b0;
         mack_q <= 1'b0;
         page_q <= '0;
         pbuf   <= '0;
         pmask  <= '0;
      end else if (start_ev) begin
         state  <= ST_SEL;
         bitcnt <= '0;
         oe_q   <= 1'b0;
         pmask  <= '0;
      end else if (stop_ev) begin
         state  <= ST_IDLE;
         oe_q   <= 1'b0;
         pmask  <= '0;
      end else begin
         case (state)
            ST_SEL, ST_AHI, ST_ALO, ST_WDAT: begin
               if (scl_rise && bitcnt != 4'd8) begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end else if (scl_fall && bitcnt == 4'd8) begin
                  bitcnt <= '0;
                  oe_q   <= 1'b1;
                  case (state)
                     ST_SEL: begin
                        if (sel_hit) begin
                           rw_q  <= shreg[0];
                           state <= ST_SEL_ACK;
                        end else begin
                           oe_q  <= 1'b0;
                           state <= ST_IDLE;
                        end
                     end
                     ST_AHI: begin
                        addr[ADDR_W-1:8] <= shreg[HI_W-1:0];
                        state            <= ST_AHI_ACK;
                     end
                     ST_ALO: begin
                        addr[7:0] <= shreg;
                        page_q    <= lo_addr[ADDR_W-1:PAGE_W];
                        state     <= ST_ALO_ACK;
                     end
                     default: begin
                        pbuf[woff]         <= shreg;
                        pmask[woff]        <= 1'b1;
                        addr[PAGE_W-1:0]   <= woff + PAGE_W'(1);
                        state              <= ST_WDAT_ACK;
                     end
                  endcase
               end
            end
            ST_SEL_ACK: begin
               if (scl_fall) begin
                  if (rw_q) begin
                     shreg  <= rd_byte;
                     oe_q   <= ~rd_byte[7];
                     bitcnt <= '0;
                     state  <= ST_RDAT;
                  end else begin
                     oe_q  <= 1'b0;
                     state <= ST_AHI;
                  end
               end
            end
            ST_AHI_ACK: begin
               if (scl_fall) begin
                  oe_q  <= 1'b0;
                  state <= ST_ALO;
               end
            end
            ST_ALO_ACK, ST_WDAT_ACK: begin
               if (scl_fall) begin
                  oe_q  <= 1'b0;
                  state <= ST_WDAT;
               end
            end
            ST_RDAT: begin
               if (scl_fall) begin
                  if (bitcnt == 4'd7) begin
                     oe_q  <= 1'b0;
                     state <= ST_RDAT_ACK;
                  end else begin
                     shreg  <= {shreg[6:0], 1'b0};
                     oe_q   <= ~shreg[6];
                     bitcnt <= bitcnt + 4'd1;
                  end
               end
            end
            ST_RDAT_ACK: begin
               if (scl_rise) begin
                  mack_q <= ~sda_s;
                  addr   <= addr + ADDR_W'(1);
               end else if (scl_fall) begin
                  if (mack_q) begin
                     shreg  <= rd_byte;
                     oe_q   <= ~rd_byte[7];
                     bitcnt <= '0;
                     state  <= ST_RDAT;
                  end else begin
                     oe_q  <= 1'b0;
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe_o = oe_q;

   // R2 / R10: an idle target never holds the data line
   a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe_o);

   // R3: the data line drive only moves while the bus clock is low
   a_r3_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

   // R6: each read acknowledge clock advances the word address by one
   a_r6_read_step: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RDAT_ACK && scl_rise && !start_ev && !stop_ev)
         |=> (addr == $past(addr) + ADDR_W'(1)));

   // R7: no select byte is accepted while the write cycle runs
   a_r7_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && state == ST_SEL) |=> (state != ST_SEL_ACK));
endmodule

// File: tb/tb_eep_two_wire_target.sv
module tb_eep_two_wire_target;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 5;
   localparam int WR         = 300;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       scl;
   logic       sda_m;
   logic [2:0] strap;
   logic       wp;
   logic       oe;
   logic       sda_line;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   logic [7:0] model [0:2047];

   assign sda_line = sda_m & ~oe;

   eep_two_wire_target #(.WR_CYCLES(WR)) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl),
      .sda_i    (sda_line),
      .strap_i  (strap),
      .wp_i     (wp),
      .sda_oe_o (oe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] dat(input int salt, input int i);
      return 8'(salt * 37 + i * 13 + 5);
   endfunction

   task automatic t_start();
      sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
      sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
   endtask

   task automatic t_stop();
      sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
   endtask

   task automatic send_bit(input bit b);
      sda_m = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
      ack = ~sda_line;
      wq(Q); scl = 1'b0; wq(Q);
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
         b[i] = sda_line;
         wq(Q); scl = 1'b0; wq(Q);
      end
      send_bit(~mack);
   endtask

   task automatic poll(input logic [2:0] sel, output bit ack);
      t_start();
      send_byte({4'b1010, sel, 1'b0}, ack);
      t_stop();
   endtask

   task automatic set_addr(input logic [10:0] a, input string req);
      bit ack;
      send_byte({4'b1010, strap, 1'b0}, ack);
      chk(ack, "R3", "write select ack", ack, 1);
      send_byte({5'b0, a[10:8]}, ack);
      chk(ack, req, "address high ack", ack, 1);
      send_byte(a[7:0], ack);
      chk(ack, req, "address low ack", ack, 1);
   endtask

   task automatic do_write(input logic [10:0] a, input int n, input int salt);
      bit ack;
      logic [7:0] d;
      t_start();
      set_addr(a, "R3");
      for (int i = 0; i < n; i++) begin
         d = dat(salt, i);
         send_byte(d, ack);
         chk(ack, "R3", "data byte ack", ack, 1);
         if (!wp) model[{a[10:4], 4'(a[3:0] + i)}] = d;
      end
      t_stop();
   endtask

   task automatic wait_ready();
      bit ack;
      int t0;
      int tries;
      t0 = cyc;
      poll(strap, ack);
      chk(!ack, "R7", "select refused while busy", ack, 0);
      tries = 0;
      while (!ack && tries < 40) begin
         poll(strap, ack);
         tries++;
      end
      chk(ack, "R7", "select accepted after busy", ack, 1);
      chk((cyc - t0) >= WR, "R7", "busy lasted at least WR_CYCLES", cyc - t0, WR);
      chk((cyc - t0) <= WR + 900, "R7", "busy ended in time", cyc - t0, WR + 900);
   endtask

   task automatic read_chk(input logic [10:0] a, input int n, input string req);
      bit ack;
      logic [7:0] b;
      t_start();
      set_addr(a, "R4");
      t_start();
      send_byte({4'b1010, strap, 1'b1}, ack);
      chk(ack, "R4", "read select ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i != n - 1, b);
         chk(b == model[11'(a + i)], req, "read data", b, model[11'(a + i)]);
      end
      t_stop();
      chk(oe == 1'b0, "R10", "released after read", oe, 0);
   endtask

   task automatic cur_read(input logic [10:0] a, input int n, input string req);
      bit ack;
      logic [7:0] b;
      t_start();
      send_byte({4'b1010, strap, 1'b1}, ack);
      chk(ack, req, "current read select ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i != n - 1, b);
         chk(b == model[11'(a + i)], req, "current read data", b, model[11'(a + i)]);
      end
      t_stop();
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      bit ack;
      logic [7:0] b;
      for (int i = 0; i < 2048; i++) model[i] = 8'hFF;
      scl = 1'b1; sda_m = 1'b1; strap = 3'b101; wp = 1'b0; rst_n = 1'b0;
      wq(5);
      rst_n = 1'b1;
      wq(5);

      // R1: reset state and erased array
      chk(oe == 1'b0, "R1", "sda released after reset", oe, 0);
      read_chk(11'h3A5, 3, "R1");
      read_chk(11'h000, 2, "R1");

      // R2: full strap / select sweep
      for (int st = 0; st < 8; st++) begin
         strap = 3'(st);
         for (int sel = 0; sel < 8; sel++) begin
            poll(3'(sel), ack);
            chk(ack == (sel == st), "R2", "select match", ack, (sel == st));
         end
      end
      strap = 3'b101;

      // R5 / R7 / R4: full page at 0, then read back
      do_write(11'h000, 16, 1);
      wait_ready();
      read_chk(11'h000, 16, "R4");

      // R6: last page, sequential read across 2047 -> 0
      do_write(11'h7F0, 16, 2);
      wait_ready();
      read_chk(11'h7FE, 4, "R6");
      cur_read(11'h002, 2, "R6");

      // R5: partial page starting at offset 14 wraps to offset 0
      do_write(11'h05E, 3, 3);
      wait_ready();
      read_chk(11'h050, 16, "R5");

      // R5: 18 bytes into one page, first two overwritten
      do_write(11'h100, 18, 4);
      wait_ready();
      read_chk(11'h100, 16, "R5");

      // R8: write protect keeps array, no busy
      wp = 1'b1;
      do_write(11'h200, 4, 5);
      poll(strap, ack);
      chk(ack, "R8", "no busy under write protect", ack, 1);
      wp = 1'b0;
      read_chk(11'h200, 4, "R8");

      // R9: repeated start during write abandons the data
      t_start();
      set_addr(11'h300, "R9");
      send_byte(8'h5A, ack);
      chk(ack, "R9", "data ack before abort", ack, 1);
      send_byte(8'hC3, ack);
      t_start();
      send_byte({4'b1010, strap, 1'b1}, ack);
      chk(ack, "R9", "read select after abort", ack, 1);
      recv_byte(1'b0, b);
      chk(b == 8'hFF, "R9", "aborted byte not stored", b, 8'hFF);
      t_stop();
      poll(strap, ack);
      chk(ack, "R9", "no busy after abort", ack, 1);
      read_chk(11'h300, 2, "R9");

      // R10: master NACK leaves target idle and bus free
      chk(oe == 1'b0 && sda_line == 1'b1, "R10", "bus idle after NACK", sda_line, 1);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule